// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is a synthesizable slave model of a byte-wide serial EEPROM on an SPI bus in mode 0. It watches chip select, serial clock, serial data in and a hold pin, all sampled by a faster system clock. It returns serial data out and acts on one-byte instruction codes. A read streams bytes from an auto-incrementing address for as long as chip select stays low. A write gathers up to one page of bytes into a buffer. After chip select rises at a legal point, a self-timed write cycle copies that buffer into the array.

A status byte reports the write-enable latch, the write-in-progress flag, two block-protect bits and a status write-disable bit. Write protection is decided by a guard input supplied from outside. The array holds 2^ADDR_W bytes: the default is 11, and 15 gives the full 32 KiB part. The write cycle lasts WR_CYCLES system clocks.

Top module: `spi_eeprom`

## Requirements
- R1: After reset the bus is ignored until a falling edge of csN is seen. Chip select held low from reset selects nothing, so an instruction sent that way leaves the status at 0x00.
- R2: Data in is sampled on sck rising edges and data out changes after sck falling edges, most significant bit first. RDSR (0x05) returns the status byte {bit7 SRWD, bits6..4 zero, bit3 BP1, bit2 BP0, bit1 WEL, bit0 WIP}, repeated for as long as csN stays low.
- R3: WREN (0x06) sets WEL and WRDI (0x04) clears it. Either takes effect only when csN rises directly after the eighth bit; any further clocked bit discards the instruction.
- R4: WRITE (0x02) takes a 16-bit address, MSB first, then data bytes. Address bits at or above ADDR_W are ignored. The bytes are stored only if WEL is 1.
- R5: Pages are 2^PAGE_W (64) bytes. Write data that runs past the end of the page wraps to the start of the same page.
- R6: After a write is accepted, WIP reads 1 for WR_CYCLES clocks. Then WIP returns to 0 and WEL is cleared.
- R7: READ (0x03) takes a 16-bit address, then streams bytes from incrementing addresses, wrapping from the last array byte to byte 0.
- R8: WRSR (0x01) with WEL set and one data byte copies data bits 7, 3 and 2 into SRWD, BP1 and BP0 when its write cycle ends.
- R9: With wpGuard high, WRITE is rejected. WRSR is rejected when wpGuard is high and SRWD is 1. A rejected instruction starts no cycle, changes no data and leaves WEL set.
- R10: While WIP is 1 every instruction except RDSR is ignored, and data out stays 0. An unknown opcode makes the rest of the frame ignored.
- R11: A WRITE whose csN rises part-way through a byte is discarded: no write cycle starts and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| holdN | input | 1 | Active-low hold; while low, serial clock edges are ignored |
| wpGuard | input | 1 | External write-protect guard |
| miso | output | 1 | Serial data out of the block; 0 when not driven with data |

## Verification
The checks assume that csN, sck and mosi are already synchronous to clk. They also assume that each level lasts at least two system clocks, and that WR_CYCLES is at least one page long, so that every page column is visited during the cycle. The bench drives every serial pin on the falling edge of clk and holds each half period of sck for four system clocks. It moves csN only while sck is low, which keeps every serial edge cleanly separated from its neighbours and from chip-select changes.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef struct packed {
    logic       addrHi;     // high address byte complete
    logic       addrLo;     // low address byte complete
    logic       readStart;  // with addrLo: fetch first read byte
    logic       readNext;   // fetch following read byte
    logic       statNext;   // load status byte for output
    logic       dataByte;   // write data byte complete
    logic       srByte;     // status data byte complete
    logic       shiftOut;   // falling sck: present next output bit
    logic       quiet;      // chip select released: drive output low
    logic       doWren;
    logic       doWrdi;
    logic       doWrsr;
    logic       doWrite;
    logic [7:0] byteVal;
  } eeStrobe_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sck,
  input  logic      mosi,
  input  logic      holdN,
  input  logic      busy,
  output eeStrobe_t stb
);
  typedef enum logic [3:0] {
    S_OP, S_AH, S_AL, S_WD, S_SR, S_RD, S_RS, S_END, S_SKIP
  } ctlState_t;

  ctlState_t  state;
  logic       prevCs, prevSck, armed, commitOk;
  logic [2:0] bitCnt;
  logic [6:0] shiftReg;
  logic [7:0] opReg;

  logic       csFall, csRise, live, sRise, sFall, byteDone;
  logic [7:0] byteNow;

  always_comb begin
    csFall   = prevCs & ~csN;
    csRise   = ~prevCs & csN;
    live     = armed & ~csN & holdN;
    sRise    = live & ~prevSck & sck;
    sFall    = live & prevSck & ~sck;
    byteDone = sRise & (bitCnt == 3'd7);
    byteNow  = {shiftReg, mosi};
  end

  always_comb begin
    stb = '0;
    stb.byteVal = byteNow;
    if (byteDone) begin
      case (state)
        S_OP:    stb.statNext  = (byteNow == OP_RDSR);
        S_AH:    stb.addrHi    = 1'b1;
        S_AL: begin
          stb.addrLo    = 1'b1;
          stb.readStart = (opReg == OP_READ);
        end
        S_WD:    stb.dataByte  = 1'b1;
        S_SR:    stb.srByte    = 1'b1;
        S_RD:    stb.readNext  = 1'b1;
        S_RS:    stb.statNext  = 1'b1;
        default: ;
      endcase
    end
    stb.shiftOut = sFall & ((state == S_RD) | (state == S_RS));
    stb.quiet    = csRise;
    if (csRise & commitOk) begin
      stb.doWren  = (opReg == OP_WREN);
      stb.doWrdi  = (opReg == OP_WRDI);
      stb.doWrsr  = (opReg == OP_WRSR);
      stb.doWrite = (opReg == OP_WRITE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCs   <= 1'b0;
      prevSck  <= 1'b0;
      armed    <= 1'b0;
      commitOk <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
      opReg    <= '0;
      state    <= S_SKIP;
    end else begin
      prevCs  <= csN;
      prevSck <= sck;
      if (csFall) begin
        armed    <= 1'b1;
        state    <= S_OP;
        bitCnt   <= '0;
        commitOk <= 1'b0;
      end else if (csRise) begin
        commitOk <= 1'b0;
        state    <= S_SKIP;
      end else if (sRise) begin
        bitCnt   <= bitCnt + 3'd1;
        shiftReg <= {shiftReg[5:0], mosi};
        if (!byteDone) begin
          if (state != S_RD && state != S_RS) commitOk <= 1'b0;
          if (state == S_END) state <= S_SKIP;
        end else begin
          case (state)
            S_OP: begin
              opReg <= byteNow;
              if (busy && byteNow != OP_RDSR) state <= S_SKIP;
              else begin
                case (byteNow)
                  OP_WRSR:           state <= S_SR;
                  OP_WRITE, OP_READ: state <= S_AH;
                  OP_WREN, OP_WRDI: begin
                    state    <= S_END;
                    commitOk <= 1'b1;
                  end
                  OP_RDSR:           state <= S_RS;
                  default:           state <= S_SKIP;
                endcase
              end
            end
            S_AH:  state <= S_AL;
            S_AL:  state <= (opReg == OP_READ) ? S_RD : S_WD;
            S_WD:  commitOk <= 1'b1;
            S_SR: begin
              state    <= S_END;
              commitOk <= 1'b1;
            end
            S_END: begin
              state    <= S_SKIP;
              commitOk <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R3: a command is committed only on a byte boundary
  p_commit_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doWren | stb.doWrdi | stb.doWrsr | stb.doWrite) |-> (bitCnt == 3'd0));
endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rstN,
  input  eeStrobe_t stb,
  input  logic      wpGuard,
  output logic      busy,
  output logic      dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]               mem     [DEPTH];
  logic [7:0]               pageBuf [PAGE];
  logic [PAGE-1:0]          fill;
  logic [ADDR_W-9:0]        addrHi;
  logic [PAGE_W-1:0]        col;
  logic [ADDR_W-PAGE_W-1:0] pageIdx;
  logic [ADDR_W-1:0]        rdPtr, aIdx;
  logic [7:0]               outReg, statByte;
  logic [2:0]               srNew;
  logic                     srwd, wel, wip, wrStat;
  logic [1:0]               bp;
  logic [CNT_W-1:0]         cnt;
  logic [PAGE_W-1:0]        progCol;
  logic                     memWe;

  always_comb begin
    aIdx     = {addrHi, stb.byteVal};
    statByte = {srwd, 3'b000, bp, wel, wip};
    progCol  = cnt[PAGE_W-1:0];
    memWe    = wip & ~wrStat & (cnt < CNT_W'(PAGE)) & fill[progCol];
    busy     = wip;
  end

  always_ff @(posedge clk) begin
    if (memWe) mem[{pageIdx, progCol}] <= pageBuf[progCol];
  end

  always_ff @(posedge clk) begin
    if (stb.dataByte) pageBuf[col] <= stb.byteVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi  <= '0;
      col     <= '0;
      pageIdx <= '0;
      rdPtr   <= '0;
      outReg  <= '0;
      dout    <= 1'b0;
      fill    <= '0;
      srNew   <= '0;
      srwd    <= 1'b0;
      bp      <= '0;
      wel     <= 1'b0;
      wip     <= 1'b0;
      wrStat  <= 1'b0;
      cnt     <= '0;
    end else begin
      if (stb.addrHi) begin
        addrHi <= stb.byteVal[ADDR_W-9:0];
        fill   <= '0;
      end
      if (stb.addrLo) begin
        col     <= aIdx[PAGE_W-1:0];
        pageIdx <= aIdx[ADDR_W-1:PAGE_W];
        if (stb.readStart) begin
          outReg <= mem[aIdx];
          rdPtr  <= aIdx + ADDR_W'(1);
        end
      end
      if (stb.readNext) begin
        outReg <= mem[rdPtr];
        rdPtr  <= rdPtr + ADDR_W'(1);
      end
      if (stb.statNext) outReg <= statByte;
      if (stb.shiftOut) begin
        dout   <= outReg[7];
        outReg <= {outReg[6:0], 1'b0};
      end
      if (stb.quiet) dout <= 1'b0;
      if (stb.dataByte) begin
        fill[col] <= 1'b1;
        col       <= col + PAGE_W'(1);
      end
      if (stb.srByte) srNew <= {stb.byteVal[7], stb.byteVal[3:2]};
      if (stb.doWren) wel <= 1'b1;
      if (stb.doWrdi) wel <= 1'b0;
      if (stb.doWrite && wel && !wpGuard) begin
        wip    <= 1'b1;
        cnt    <= '0;
        wrStat <= 1'b0;
      end
      if (stb.doWrsr && wel && !(srwd && wpGuard)) begin
        wip    <= 1'b1;
        cnt    <= '0;
        wrStat <= 1'b1;
      end
      if (wip) begin
        if (cnt == CNT_W'(WR_CYCLES - 1)) begin
          wip <= 1'b0;
          wel <= 1'b0;
          if (wrStat) {srwd, bp} <= srNew;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R3: a write cycle only starts with the latch set
  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel));
  // R6: the latch is clear once the cycle ends
  p_end_clears_wel_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);
  // R10: no commit arrives while a cycle runs
  p_idle_commit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doWrite | stb.doWrsr | stb.doWren | stb.doWrdi) |-> !wip);
  // R9: an array cycle never starts under the guard
  p_guard_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wip) && !wrStat) |-> !$past(wpGuard));
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic holdN,
  input  logic wpGuard,
  output logic miso
);
  eeStrobe_t stb;
  logic      busy;

  eeprom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .holdN(holdN), .busy(busy), .stb(stb)
  );

  eeprom_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wpGuard(wpGuard),
    .busy(busy), .dout(miso)
  );
endmodule

// File: tb/sim_spi_eeprom.sv
`timescale 1ns/1ps
module sim_spi_eeprom;
  localparam int WRC = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic holdN = 1'b1;
  logic wpGuard = 1'b0;
  logic miso;
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  spi_eeprom #(.ADDR_W(11), .PAGE_W(6), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .holdN(holdN), .wpGuard(wpGuard), .miso(miso)
  );

  // {address[15:0], data[7:0]}; addresses stay distinct in their low 11 bits
  localparam logic [23:0] VEC [6] = '{
    24'h0005A5, 24'h07FF3C, 24'hF81281, 24'h04007E, 24'h0233C3, 24'h01015A
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic sel();
    csN = 1'b0;
    tick(4);
  endtask

  task automatic desel();
    tick(4);
    csN = 1'b1;
    tick(6);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      tick(4);
      rx[i] = miso;
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, dummy);
  endtask

  task automatic bits(int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); put(op); desel();
  endtask

  task automatic rdsr(output logic [7:0] st);
    sel(); put(8'h05); xfer(8'h00, st); desel();
  endtask

  task automatic wrByte(input logic [15:0] a, input logic [7:0] d);
    cmd1(8'h06);
    sel(); put(8'h02); put(a[15:8]); put(a[7:0]); put(d); desel();
  endtask

  task automatic rdByte(input logic [15:0] a, output logic [7:0] d);
    sel(); put(8'h03); put(a[15:8]); put(a[7:0]); xfer(8'h00, d); desel();
  endtask

  initial begin
    logic [7:0] r, r2;
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1: chip select low since reset, no falling edge yet
    put(8'h06);
    tick(4);
    csN = 1'b1;
    tick(6);
    chk("R1 no select without falling edge", miso, 8'h00);
    rdsr(r);
    chk("R1 status after unarmed WREN", r, 8'h00);

    // R2: status repeats while selected
    sel(); put(8'h05); xfer(8'h00, r); xfer(8'h00, r2); desel();
    chk("R2 status first", r, 8'h00);
    chk("R2 status repeat", r2, 8'h00);

    // R3: latch set, cleared, and discard on extra bits
    cmd1(8'h06); rdsr(r); chk("R3 WREN sets WEL", r, 8'h02);
    cmd1(8'h04); rdsr(r); chk("R3 WRDI clears WEL", r, 8'h00);
    sel(); put(8'h06); bits(3); desel(); rdsr(r);
    chk("R3 WREN with extra bits discarded", r, 8'h00);

    // R10: unknown opcode voids the rest of the frame
    sel(); put(8'h9A); put(8'h06); desel(); rdsr(r);
    chk("R10 unknown opcode ignored", r, 8'h00);

    // R4 R6: table of single-byte writes
    foreach (VEC[k]) begin
      wrByte(VEC[k][23:8], VEC[k][7:0]);
      rdsr(r);
      chk("R6 WIP and WEL during cycle", r, 8'h03);
      if (k == 0) begin
        rdByte(16'h0005, r2);
        chk("R10 READ ignored while busy", r2, 8'h00);
      end
      tick(WRC + 50);
      rdsr(r);
      chk("R6 WIP and WEL clear after cycle", r, 8'h00);
    end
    foreach (VEC[k]) begin
      rdByte(VEC[k][23:8] & 16'h07FF, r);
      chk("R4 readback, upper address bits ignored", r, VEC[k][7:0]);
    end

    // R9: guard blocks an array write and keeps WEL
    wpGuard = 1'b1;
    wrByte(16'h0005, 8'hFF);
    rdsr(r); chk("R9 guarded WRITE rejected, WEL kept", r, 8'h02);
    rdByte(16'h0005, r); chk("R9 data unchanged", r, 8'hA5);
    wpGuard = 1'b0;
    cmd1(8'h04);

    // R8: status write
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h8C); desel();
    rdsr(r); chk("R8 WRSR busy", r, 8'h03);
    tick(WRC + 50);
    rdsr(r); chk("R8 WRSR stored SRWD BP1 BP0", r, 8'h8C);
    wpGuard = 1'b1;
    cmd1(8'h06);
    sel(); put(8'h01); put(8'h00); desel();
    rdsr(r); chk("R9 WRSR rejected by SRWD and guard", r, 8'h8E);
    wpGuard = 1'b0;
    sel(); put(8'h01); put(8'h00); desel();
    tick(WRC + 50);
    rdsr(r); chk("R8 WRSR clears bits", r, 8'h00);

    // R5 R7: page write wrapping, read wrapping
    cmd1(8'h06);
    sel(); put(8'h02); put(8'h00); put(8'h3C);
    for (int i = 0; i < 6; i++) put(8'h10 + 8'(i) * 8'h11);
    desel();
    tick(WRC + 50);
    sel(); put(8'h03); put(8'h07); put(8'hFF);
    xfer(8'h00, r); chk("R7 read last byte", r, 8'h3C);
    xfer(8'h00, r); chk("R7 read wraps to byte 0", r, 8'h54);
    xfer(8'h00, r); chk("R7 read byte 1", r, 8'h65);
    desel();
    sel(); put(8'h03); put(8'h00); put(8'h3C);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, r);
      chk("R5 page tail bytes", r, 8'h10 + 8'(i) * 8'h11);
    end
    desel();

    // R11: write ended mid-byte
    cmd1(8'h06);
    sel(); put(8'h02); put(8'h02); put(8'h33); put(8'h11); bits(4); desel();
    rdsr(r); chk("R11 partial WRITE starts no cycle", r, 8'h02);
    rdByte(16'h0233, r); chk("R11 data unchanged", r, 8'hC3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule